// File: doc/BRIEF.md
# Scoreboard Hazard Controller

This block is the central control unit of an out-of-order floating-point pipeline. It keeps a status entry for each functional unit and a result table for the register file. Each cycle it decides which instructions may advance. At most one decoded instruction per cycle enters a free unit of the class it needs. Units whose sources are ready are told to read the register file. Units that report completion are allowed to write back once doing so cannot destroy a value that another unit still has to read.

Each hazard is resolved at a different stage. A pending write to the same destination (WAW) holds the instruction at issue, and the issue-stall output then holds the front end. A source whose producer has not yet written (RAW) holds the consuming unit before operand read. A unit that still has to read the old contents of a destination (WAR) delays only the write-back of the unit that targets that register. Every result broadcast wakes the units that wait on the writer. The datapath, the register file contents and instruction fetch are outside this block.

Top module: `sb_ctrl`

## Requirements
- R1: After reset no unit is busy and no register has a pending writer. With no issue request, every grant output, the stall output and both register-file enables are low.
- R2: Unit indices are fixed. Index 0 is integer/memory (class code 0), index 1 is the FP adder (class 1), indices 2 to 1+N_MUL are FP multipliers (class 2), and the last index is the FP divider (class 3). A request that is accepted raises exactly one bit of `iss_gnt_o` in the same cycle: the lowest-indexed free unit of the requested class.
- R3: When no unit of the requested class is free, `iss_stall_o` is high and `iss_gnt_o` is zero.
- R4: When the destination register has a pending writer, the request stalls (WAW). It issues in the cycle after that writer's write-back grant.
- R5: A unit gets a read grant only when neither of its sources has a pending producer. A unit issued with ready sources reads in the next cycle. A unit waiting on a producer reads in the cycle after that producer's write-back grant.
- R6: A read grant lasts one cycle and moves the unit to execution. A `done_i` bit is acted on only for a unit in execution, and that unit requests write-back from the next cycle. A `done_i` bit for any other unit is ignored.
- R7: A unit waiting to write register D is not granted while another unit holds D as a source it has not yet read (WAR). It is granted in the cycle after that read.
- R8: Among eligible writers the lowest index is granted, and the others retry in later cycles.
- R9: A write-back frees the unit and clears its register entry. The unit can take a new instruction in the next cycle. A consumer issued in the same cycle as its producer's write-back treats that source as ready.
- R10: `rf_rd_en_o` is high in any cycle with a read grant. `rf_wr_en_o` is high with a write grant, and `rf_wr_addr_o` then carries the writer's destination register.
- R11: `fu_op_o` slice i (OP_W bits at i*OP_W) holds the operation code captured when unit i last issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| iss_valid_i | input | 1 | Decoded instruction offered for issue |
| iss_cls_i | input | 2 | Unit class needed (0 int, 1 add, 2 mul, 3 div) |
| iss_op_i | input | OP_W | Operation code |
| iss_dst_i | input | $clog2(NREG) | Destination register |
| iss_src1_i | input | $clog2(NREG) | First source register |
| iss_src2_i | input | $clog2(NREG) | Second source register |
| done_i | input | 3+N_MUL | Per-unit execution-complete pulse |
| iss_stall_o | output | 1 | Offered instruction cannot issue this cycle |
| iss_gnt_o | output | 3+N_MUL | One-hot unit receiving the instruction |
| rd_gnt_o | output | 3+N_MUL | Per-unit operand-read grant |
| wr_gnt_o | output | 3+N_MUL | Per-unit write-back grant |
| fu_op_o | output | (3+N_MUL)*OP_W | Operation code held by each unit |
| rf_rd_en_o | output | 1 | Some unit reads the register file |
| rf_wr_en_o | output | 1 | A unit writes the register file |
| rf_wr_addr_o | output | $clog2(NREG) | Register being written |

## Verification
The bench builds the block with NREG=16, N_MUL=2 and OP_W=4. This gives five units, and two of them share the multiplier class. That sharing makes the structural stall, the lowest-index choice among free multipliers and the write-back priority between two units finishing together all reachable with short sequences. Sixteen registers let each scenario use its own destinations, so the expected write-back order stays unambiguous. The sequences also cover a WAR hold of several cycles and a consumer issued in the same cycle as its producer's write-back.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum logic [1:0] {
    CLS_INT = 2'd0,
    CLS_ADD = 2'd1,
    CLS_MUL = 2'd2,
    CLS_DIV = 2'd3
  } fu_cls_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RDOP,
    ST_EXEC,
    ST_WRB
  } fu_st_e;

  function automatic fu_cls_e fu_cls_of(input int idx, input int n_mul);
    if (idx == 0) return CLS_INT;
    else if (idx == 1) return CLS_ADD;
    else if (idx <= 1 + n_mul) return CLS_MUL;
    else return CLS_DIV;
  endfunction
endpackage

// File: rtl/sb_reg_table.sv
module sb_reg_table #(
  parameter int NREG = 32,
  parameter int RW   = 5,
  parameter int UW   = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          set_i,
  input  logic [RW-1:0] set_reg_i,
  input  logic [UW-1:0] set_fu_i,
  input  logic          clr_i,
  input  logic [RW-1:0] clr_reg_i,
  input  logic [RW-1:0] lk_a_i,
  input  logic [RW-1:0] lk_b_i,
  input  logic [RW-1:0] lk_d_i,
  output logic          a_pend_o,
  output logic [UW-1:0] a_fu_o,
  output logic          b_pend_o,
  output logic [UW-1:0] b_fu_o,
  output logic          d_pend_o
);
  logic [NREG-1:0] pend_q;
  logic [UW-1:0]   fu_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      for (int r = 0; r < NREG; r++) fu_q[r] <= '0;
    end else begin
      if (clr_i) pend_q[clr_reg_i] <= 1'b0;
      // set wins; WAW check keeps set and clear on distinct registers
      if (set_i) begin
        pend_q[set_reg_i] <= 1'b1;
        fu_q[set_reg_i]   <= set_fu_i;
      end
    end
  end

  assign a_pend_o = pend_q[lk_a_i];
  assign a_fu_o   = fu_q[lk_a_i];
  assign b_pend_o = pend_q[lk_b_i];
  assign b_fu_o   = fu_q[lk_b_i];
  assign d_pend_o = pend_q[lk_d_i];
endmodule

// File: rtl/sb_fu_entry.sv
module sb_fu_entry
  import sb_pkg::*;
#(
  parameter int RW   = 5,
  parameter int OP_W = 4,
  parameter int UW   = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            iss_i,
  input  logic [OP_W-1:0] op_i,
  input  logic [RW-1:0]   dst_i,
  input  logic [RW-1:0]   s1_i,
  input  logic [RW-1:0]   s2_i,
  input  logic            q1_pend_i,
  input  logic [UW-1:0]   q1_fu_i,
  input  logic            q2_pend_i,
  input  logic [UW-1:0]   q2_fu_i,
  input  logic            wb_i,
  input  logic [UW-1:0]   wb_fu_i,
  input  logic            done_i,
  input  logic            wr_gnt_i,
  output logic            busy_o,
  output logic            rd_gnt_o,
  output logic            wr_req_o,
  output logic [OP_W-1:0] op_o,
  output logic [RW-1:0]   dst_o,
  output logic [RW-1:0]   s1_o,
  output logic [RW-1:0]   s2_o,
  output logic            rj_o,
  output logic            rk_o
);
  fu_st_e        st_q;
  logic          rj_q, rk_q, qjv_q, qkv_q;
  logic [UW-1:0] qj_q, qk_q;
  logic          j_wait, k_wait, hit_j, hit_k;

  // producer writing back this very cycle counts as already done
  assign j_wait = q1_pend_i && !(wb_i && wb_fu_i == q1_fu_i);
  assign k_wait = q2_pend_i && !(wb_i && wb_fu_i == q2_fu_i);
  assign hit_j  = qjv_q && wb_i && wb_fu_i == qj_q;
  assign hit_k  = qkv_q && wb_i && wb_fu_i == qk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      rj_q  <= 1'b0;
      rk_q  <= 1'b0;
      qjv_q <= 1'b0;
      qkv_q <= 1'b0;
      qj_q  <= '0;
      qk_q  <= '0;
      op_o  <= '0;
      dst_o <= '0;
      s1_o  <= '0;
      s2_o  <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (iss_i) begin
          st_q  <= ST_RDOP;
          op_o  <= op_i;
          dst_o <= dst_i;
          s1_o  <= s1_i;
          s2_o  <= s2_i;
          qjv_q <= j_wait;
          qkv_q <= k_wait;
          qj_q  <= q1_fu_i;
          qk_q  <= q2_fu_i;
          rj_q  <= !j_wait;
          rk_q  <= !k_wait;
        end
        ST_RDOP: if (rd_gnt_o) begin
          st_q <= ST_EXEC;
          rj_q <= 1'b0;
          rk_q <= 1'b0;
        end else begin
          if (hit_j) begin
            rj_q  <= 1'b1;
            qjv_q <= 1'b0;
          end
          if (hit_k) begin
            rk_q  <= 1'b1;
            qkv_q <= 1'b0;
          end
        end
        ST_EXEC: if (done_i) st_q <= ST_WRB;
        ST_WRB:  if (wr_gnt_i) st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o   = st_q != ST_IDLE;
  assign rd_gnt_o = st_q == ST_RDOP && rj_q && rk_q;
  assign wr_req_o = st_q == ST_WRB;
  assign rj_o     = rj_q;
  assign rk_o     = rk_q;
endmodule

// File: rtl/sb_wr_arb.sv
module sb_wr_arb #(
  parameter int N  = 5,
  parameter int UW = 3
) (
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  gnt_o,
  output logic [UW-1:0] idx_o,
  output logic          vld_o
);
  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        gnt_o    = '0;
        gnt_o[i] = 1'b1;
        idx_o    = UW'(i);
      end
    end
  end
  assign vld_o = |req_i;
endmodule

// File: rtl/sb_ctrl.sv
module sb_ctrl
  import sb_pkg::*;
#(
  parameter int NREG  = 32,
  parameter int N_MUL = 2,
  parameter int OP_W  = 4,
  localparam int RW   = $clog2(NREG),
  localparam int NFU  = 3 + N_MUL
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                iss_valid_i,
  input  logic [1:0]          iss_cls_i,
  input  logic [OP_W-1:0]     iss_op_i,
  input  logic [RW-1:0]       iss_dst_i,
  input  logic [RW-1:0]       iss_src1_i,
  input  logic [RW-1:0]       iss_src2_i,
  input  logic [NFU-1:0]      done_i,
  output logic                iss_stall_o,
  output logic [NFU-1:0]      iss_gnt_o,
  output logic [NFU-1:0]      rd_gnt_o,
  output logic [NFU-1:0]      wr_gnt_o,
  output logic [NFU*OP_W-1:0] fu_op_o,
  output logic                rf_rd_en_o,
  output logic                rf_wr_en_o,
  output logic [RW-1:0]       rf_wr_addr_o
);
  localparam int UW = $clog2(NFU);

  logic [NFU-1:0] busy_w, wr_req_w, war_blk, cls_hit, sel_oh, rj_w, rk_w;
  logic [RW-1:0]  dst_w [NFU];
  logic [RW-1:0]  s1_w  [NFU];
  logic [RW-1:0]  s2_w  [NFU];
  logic [OP_W-1:0] op_w [NFU];
  logic [UW-1:0]  sel_idx, wb_idx, a_fu, b_fu;
  logic           any_free, issue_ok, wb_vld, a_pend, b_pend, d_pend;

  // issue: lowest free unit of the requested class
  always_comb begin
    sel_oh  = '0;
    sel_idx = '0;
    for (int i = NFU - 1; i >= 0; i--) begin
      if (!busy_w[i] && cls_hit[i]) begin
        sel_oh    = '0;
        sel_oh[i] = 1'b1;
        sel_idx   = UW'(i);
      end
    end
  end

  assign any_free    = |(~busy_w & cls_hit);
  assign issue_ok    = iss_valid_i && any_free && !d_pend;
  assign iss_stall_o = iss_valid_i && !issue_ok;
  assign iss_gnt_o   = issue_ok ? sel_oh : '0;

  // WAR: hold a writer while another unit has not yet read its destination
  always_comb begin
    for (int w = 0; w < NFU; w++) begin
      war_blk[w] = 1'b0;
      for (int u = 0; u < NFU; u++) begin
        if (u != w && ((rj_w[u] && s1_w[u] == dst_w[w]) ||
                       (rk_w[u] && s2_w[u] == dst_w[w])))
          war_blk[w] = 1'b1;
      end
    end
  end

  sb_wr_arb #(.N(NFU), .UW(UW)) u_arb (
    .req_i (wr_req_w & ~war_blk),
    .gnt_o (wr_gnt_o),
    .idx_o (wb_idx),
    .vld_o (wb_vld)
  );

  sb_reg_table #(.NREG(NREG), .RW(RW), .UW(UW)) u_tab (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (issue_ok),
    .set_reg_i (iss_dst_i),
    .set_fu_i  (sel_idx),
    .clr_i     (wb_vld),
    .clr_reg_i (dst_w[wb_idx]),
    .lk_a_i    (iss_src1_i),
    .lk_b_i    (iss_src2_i),
    .lk_d_i    (iss_dst_i),
    .a_pend_o  (a_pend),
    .a_fu_o    (a_fu),
    .b_pend_o  (b_pend),
    .b_fu_o    (b_fu),
    .d_pend_o  (d_pend)
  );

  for (genvar g = 0; g < NFU; g++) begin : g_fu
    localparam fu_cls_e CLS = fu_cls_of(g, N_MUL);
    assign cls_hit[g] = iss_cls_i == CLS;

    sb_fu_entry #(.RW(RW), .OP_W(OP_W), .UW(UW)) u_fu (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .iss_i     (iss_gnt_o[g]),
      .op_i      (iss_op_i),
      .dst_i     (iss_dst_i),
      .s1_i      (iss_src1_i),
      .s2_i      (iss_src2_i),
      .q1_pend_i (a_pend),
      .q1_fu_i   (a_fu),
      .q2_pend_i (b_pend),
      .q2_fu_i   (b_fu),
      .wb_i      (wb_vld),
      .wb_fu_i   (wb_idx),
      .done_i    (done_i[g]),
      .wr_gnt_i  (wr_gnt_o[g]),
      .busy_o    (busy_w[g]),
      .rd_gnt_o  (rd_gnt_o[g]),
      .wr_req_o  (wr_req_w[g]),
      .op_o      (op_w[g]),
      .dst_o     (dst_w[g]),
      .s1_o      (s1_w[g]),
      .s2_o      (s2_w[g]),
      .rj_o      (rj_w[g]),
      .rk_o      (rk_w[g])
    );

    assign fu_op_o[g*OP_W +: OP_W] = op_w[g];
  end

  assign rf_rd_en_o   = |rd_gnt_o;
  assign rf_wr_en_o   = wb_vld;
  assign rf_wr_addr_o = wb_vld ? dst_w[wb_idx] : '0;
endmodule

// File: rtl/sb_ctrl_chk.sv
module sb_ctrl_chk #(
  parameter int N_MUL = 2,
  localparam int NFU  = 3 + N_MUL
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           iss_valid_i,
  input logic           iss_stall_i,
  input logic [NFU-1:0] iss_gnt_i,
  input logic [NFU-1:0] rd_gnt_i,
  input logic [NFU-1:0] wr_gnt_i
);
  AST_ISS_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(iss_gnt_i)); // R2

  AST_ISS_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iss_valid_i && !iss_stall_i) |-> iss_gnt_i != '0); // R2

  AST_STALL_NO_GNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iss_stall_i |-> iss_gnt_i == '0); // R3

  AST_ISS_NOT_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iss_gnt_i != '0) |-> (iss_gnt_i & rd_gnt_i) == '0); // R5

  AST_READ_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_gnt_i != '0) |=> (rd_gnt_i & $past(rd_gnt_i)) == '0); // R6

  AST_WR_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_gnt_i)); // R8

  AST_WR_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_gnt_i != '0) |=> (wr_gnt_i & $past(wr_gnt_i)) == '0); // R9
endmodule

bind sb_ctrl sb_ctrl_chk #(.N_MUL(N_MUL)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .iss_valid_i (iss_valid_i),
  .iss_stall_i (iss_stall_o),
  .iss_gnt_i   (iss_gnt_o),
  .rd_gnt_i    (rd_gnt_o),
  .wr_gnt_i    (wr_gnt_o)
);

// File: tb/sim_sb_ctrl.sv
module sim_sb_ctrl;
  localparam int NREG = 16;
  localparam int NMUL = 2;
  localparam int OPW  = 4;
  localparam int RW   = $clog2(NREG);
  localparam int NFU  = 3 + NMUL;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             iss_valid_i = 1'b0;
  logic [1:0]       iss_cls_i = '0;
  logic [OPW-1:0]   iss_op_i = '0;
  logic [RW-1:0]    iss_dst_i = '0, iss_src1_i = '0, iss_src2_i = '0;
  logic [NFU-1:0]   done_i = '0;
  logic             iss_stall_o, rf_rd_en_o, rf_wr_en_o;
  logic [NFU-1:0]   iss_gnt_o, rd_gnt_o, wr_gnt_o;
  logic [NFU*OPW-1:0] fu_op_o;
  logic [RW-1:0]    rf_wr_addr_o;

  int n_chk = 0;
  int n_err = 0;
  bit fin = 1'b0;
  int exp_q[$];

  always #5 clk_i = ~clk_i;

  sb_ctrl #(.NREG(NREG), .N_MUL(NMUL), .OP_W(OPW)) u0 (.*);

  task automatic ck(input string rq, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s act=%0d exp=%0d", rq, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk_i);
    #1;
    done_i = '0;
  endtask

  task automatic iss(input int cls, input int op, input int d, input int a, input int b);
    iss_valid_i = 1'b1;
    iss_cls_i   = 2'(cls);
    iss_op_i    = OPW'(op);
    iss_dst_i   = RW'(d);
    iss_src1_i  = RW'(a);
    iss_src2_i  = RW'(b);
  endtask

  task automatic noiss();
    iss_valid_i = 1'b0;
  endtask

  task automatic expect_wr(input int addr);
    exp_q.push_back(addr);
  endtask

  // monitor: every register write must match the next expected item
  always @(negedge clk_i) begin
    if (rst_ni && rf_wr_en_o) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_err++;
        $display("FAIL R10 unexpected write act=%0d exp=none", rf_wr_addr_o);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (int'(rf_wr_addr_o) != e) begin
          n_err++;
          $display("FAIL R10 write order act=%0d exp=%0d", rf_wr_addr_o, e);
        end
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    cyc();
    #1;
    ck("R1 stall", iss_stall_o, 0);
    ck("R1 rd_gnt", rd_gnt_o, 0);
    ck("R1 wr_gnt", wr_gnt_o, 0);
    ck("R1 rf_wr_en", rf_wr_en_o, 0);
    ck("R1 rf_rd_en", rf_rd_en_o, 0);

    // basic add flow, done on idle unit ignored
    expect_wr(1);
    iss(1, 5, 1, 2, 3); #1;
    ck("R2 add gnt", iss_gnt_o, 2);
    ck("R2 no stall", iss_stall_o, 0);
    cyc(); noiss(); #1;
    ck("R5 add read", rd_gnt_o, 2);
    ck("R10 rd_en", rf_rd_en_o, 1);
    ck("R11 op", fu_op_o[1*OPW +: OPW], 5);
    cyc(); done_i = 5'b00011; #1;
    ck("R6 read one cycle", rd_gnt_o, 0);
    ck("R6 no early write", wr_gnt_o, 0);
    cyc(); #1;
    ck("R6 write after done", wr_gnt_o, 2);
    ck("R10 wr_en", rf_wr_en_o, 1);
    ck("R10 wr_addr", rf_wr_addr_o, 1);
    cyc(); #1;
    ck("R6 idle done ignored", wr_gnt_o, 0);

    // multipliers: structural stall and write priority
    expect_wr(4); expect_wr(5); expect_wr(6);
    iss(2, 1, 4, 0, 0); #1;
    ck("R2 mul0 gnt", iss_gnt_o, 4);
    cyc(); iss(2, 2, 5, 0, 0); #1;
    ck("R2 mul1 gnt", iss_gnt_o, 8);
    ck("R5 mul0 read", rd_gnt_o, 4);
    cyc(); iss(2, 3, 6, 0, 0); #1;
    ck("R3 stall", iss_stall_o, 1);
    ck("R3 no gnt", iss_gnt_o, 0);
    ck("R5 mul1 read", rd_gnt_o, 8);
    cyc(); done_i = 5'b01100; #1;
    ck("R3 still stalled", iss_stall_o, 1);
    cyc(); #1;
    ck("R8 low index wins", wr_gnt_o, 4);
    ck("R10 wr_addr mul0", rf_wr_addr_o, 4);
    ck("R3 stall until free", iss_stall_o, 1);
    cyc(); #1;
    ck("R8 loser retries", wr_gnt_o, 8);
    ck("R9 freed unit reused", iss_gnt_o, 4);
    ck("R9 no stall", iss_stall_o, 0);
    cyc(); noiss(); #1;
    ck("R11 op reloaded", fu_op_o[2*OPW +: OPW], 3);
    ck("R5 reissued read", rd_gnt_o, 4);
    cyc(); done_i = 5'b00100;
    cyc(); #1;
    ck("R6 mul write", wr_gnt_o, 4);
    cyc();

    // WAW on r7
    expect_wr(7); expect_wr(7);
    iss(3, 0, 7, 1, 1); #1;
    ck("R2 div gnt", iss_gnt_o, 16);
    cyc(); iss(1, 0, 7, 2, 2); #1;
    ck("R4 waw stall", iss_stall_o, 1);
    ck("R5 div read", rd_gnt_o, 16);
    cyc(); done_i = 5'b10000; #1;
    ck("R4 waw hold", iss_stall_o, 1);
    cyc(); #1;
    ck("R4 div writes", wr_gnt_o, 16);
    ck("R4 stall during write", iss_stall_o, 1);
    cyc(); #1;
    ck("R4 issue after write", iss_gnt_o, 2);
    cyc(); noiss(); #1;
    ck("R5 add read", rd_gnt_o, 2);
    cyc(); done_i = 5'b00010;
    cyc(); #1;
    ck("R6 add write", wr_gnt_o, 2);
    cyc();

    // RAW on r8
    expect_wr(8); expect_wr(9);
    iss(2, 0, 8, 1, 2); #1;
    ck("R2 mul gnt", iss_gnt_o, 4);
    cyc(); iss(1, 0, 9, 8, 3); #1;
    ck("R2 add gnt", iss_gnt_o, 2);
    cyc(); noiss(); done_i = 5'b00100; #1;
    ck("R5 raw wait", rd_gnt_o, 0);
    cyc(); #1;
    ck("R5 producer writes", wr_gnt_o, 4);
    ck("R5 raw wait at write", rd_gnt_o, 0);
    cyc(); #1;
    ck("R5 read after write", rd_gnt_o, 2);
    cyc(); done_i = 5'b00010;
    cyc(); #1;
    ck("R6 consumer write", wr_gnt_o, 2);
    cyc();

    // issue in the producer's write-back cycle
    expect_wr(10); expect_wr(11);
    iss(2, 0, 10, 0, 0); #1;
    ck("R2 mul gnt", iss_gnt_o, 4);
    cyc(); noiss();
    cyc(); done_i = 5'b00100;
    cyc(); iss(1, 0, 11, 10, 10); #1;
    ck("R9 producer write", wr_gnt_o, 4);
    ck("R9 same cycle issue", iss_gnt_o, 2);
    cyc(); noiss(); #1;
    ck("R9 bypass ready", rd_gnt_o, 2);
    cyc(); done_i = 5'b00010;
    cyc(); #1;
    ck("R6 consumer write", wr_gnt_o, 2);
    cyc();

    // WAR on r15
    expect_wr(13); expect_wr(15); expect_wr(14);
    iss(2, 0, 13, 0, 0); #1;
    ck("R2 mul gnt", iss_gnt_o, 4);
    cyc(); iss(3, 0, 14, 13, 15); #1;
    ck("R2 div gnt", iss_gnt_o, 16);
    cyc(); iss(1, 0, 15, 0, 0); #1;
    ck("R7 war not issue hazard", iss_gnt_o, 2);
    ck("R5 div waits", rd_gnt_o, 0);
    cyc(); noiss(); #1;
    ck("R5 add read", rd_gnt_o, 2);
    cyc(); done_i = 5'b00010;
    cyc(); #1;
    ck("R7 war hold", wr_gnt_o, 0);
    cyc(); done_i = 5'b00100; #1;
    ck("R7 war hold 2", wr_gnt_o, 0);
    cyc(); #1;
    ck("R7 blocked loses to mul", wr_gnt_o, 4);
    ck("R10 addr 13", rf_wr_addr_o, 13);
    cyc(); #1;
    ck("R7 hold during read", wr_gnt_o, 0);
    ck("R5 div reads", rd_gnt_o, 16);
    cyc(); #1;
    ck("R7 write after read", wr_gnt_o, 2);
    ck("R10 addr 15", rf_wr_addr_o, 15);
    cyc(); done_i = 5'b10000;
    cyc(); #1;
    ck("R6 div write", wr_gnt_o, 16);
    cyc(); cyc();

    ck("R10 all writes seen", exp_q.size(), 0);
    fin = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!fin) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule